// File: doc/BRIEF.md
# Typed-Field Control/Status Register

This block is one control/status register whose bits are split into fields. Each field has its own access behaviour, which settles who owns the field: the bus initiator, the peripheral logic, or both. On the bus side the register is a single word port. It has a read strobe, a write strobe, write data and read data. The read data is combinational, so it is valid in the same cycle as the read strobe. On the peripheral side each field brings out only the signals its behaviour needs.

Fields are packed from the least significant bit upward, in the order they are declared. The register is as wide as the sum of its field widths. The instance provided holds six 4-bit fields, from the lowest bits up:
- a bus-owned control value;
- a pending flag set, cleared by writing one;
- an arm flag set, set by writing one;
- a peripheral-owned status value;
- a write-only command slice;
- a reserved field.

Flag conflicts between the bus and the peripheral are resolved bit by bit in one cycle, with a fixed winner for each flag type. The block has no state machine. Its only sequential state is three field registers, and each is reloaded on every clock edge.

Top module: `typed_csr_reg`

## Requirements
- R1: The field layout is fixed. Control is bits [3:0], pending is bits [7:4], arm is bits [11:8], status is bits [15:12], command is bits [19:16] and reserved is bits [23:20]. bus_rd_data always shows the stored control, pending and arm values at their positions.
- R2: The control field resets to CTL_RST (default 4'hA). On the clock edge that samples bus_wr_stb high, ctl_q loads bus_wr_data[3:0]. At any other edge it holds.
- R3: For pending bits, a 1 in bus_wr_data[7:4] under bus_wr_stb clears the bit at the next edge, and a 1 on pend_set sets it. When both hit the same bit in one cycle, the bit ends up 1. The field resets to 0.
- R4: For arm bits, a 1 in bus_wr_data[11:8] under bus_wr_stb sets the bit at the next edge, and a 1 on arm_clr clears it. When both hit the same bit in one cycle, the bit ends up 1. The field resets to 0.
- R5: Writing 0 to a flag bit leaves that bit as it was. Each flag bit changes only through its own write bit or its own peripheral input.
- R6: bus_rd_data[15:12] equals stat_in in the same cycle, and stat_rd_stb equals bus_rd_stb.
- R7: cmd_data equals bus_wr_data[19:16] and cmd_stb equals bus_wr_stb. The command bits read back as 0 and store nothing.
- R8: The reserved bits [23:20] always read back as 0. Writing them changes no other field and drives no peripheral signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd_stb | input | 1 | Bus read strobe |
| bus_wr_stb | input | 1 | Bus write strobe |
| bus_wr_data | input | 24 | Bus write data |
| bus_rd_data | output | 24 | Bus read data |
| ctl_q | output | 4 | Stored control value |
| pend_q | output | 4 | Stored pending flags |
| pend_set | input | 4 | Peripheral set for pending flags |
| arm_q | output | 4 | Stored arm flags |
| arm_clr | input | 4 | Peripheral clear for arm flags |
| stat_in | input | 4 | Peripheral status value |
| stat_rd_stb | output | 1 | Pulses when the register is read |
| cmd_data | output | 4 | Command slice of the write data |
| cmd_stb | output | 1 | Pulses when the register is written |

## Verification
The hardest situations to reach are same-bit, same-cycle conflicts between a bus write of 1 and a peripheral set or clear. Random stimulus alone rarely lines these up on a bit whose stored value can show the result. The bench therefore first drives the flag fields to a known state. It then issues directed cycles in which the write data and the peripheral input overlap on chosen bits and differ on others. A constrained random phase with sparse peripheral inputs follows, checked every cycle against a model.

// File: rtl/csr_field_pkg.sv
package csr_field_pkg;

    typedef enum logic [2:0] {
        FK_RW,
        FK_W1C,
        FK_W1S,
        FK_RO,
        FK_WO,
        FK_RSV
    } field_kind_e;

endpackage

// File: rtl/csr_field_store.sv
module csr_field_store #(
    parameter csr_field_pkg::field_kind_e KIND = csr_field_pkg::FK_RW,
    parameter int W = 4,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic [W-1:0] wr_bits,
    input  logic [W-1:0] side_in,
    output logic [W-1:0] q
);
    localparam bit IS_RW  = (KIND == csr_field_pkg::FK_RW);
    localparam bit IS_W1C = (KIND == csr_field_pkg::FK_W1C);
    localparam bit IS_W1S = (KIND == csr_field_pkg::FK_W1S);

    logic [W-1:0] wr_ones;
    logic [W-1:0] side_v;
    logic [W-1:0] nxt;

    assign wr_ones = wr_stb ? wr_bits : '0;
    assign side_v  = side_in & {W{!IS_RW}};

    always_comb begin
        nxt = q;
        if (IS_RW) begin
            nxt = wr_stb ? wr_bits : q;
        end else if (IS_W1C) begin
            // peripheral set beats bus clear
            nxt = (q & ~wr_ones) | side_v;
        end else if (IS_W1S) begin
            // bus set beats peripheral clear
            nxt = (q & ~side_v) | wr_ones;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST;
        end else begin
            q <= nxt;
        end
    end

    generate
        if (IS_RW) begin : g_rw_chk
            assert_rw_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
                wr_stb |=> q == $past(wr_bits));
            assert_rw_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_stb |=> $stable(q));
        end else if (IS_W1C) begin : g_w1c_chk
            assert_w1c_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (|side_in) |=> (q & $past(side_in)) == $past(side_in));
            assert_w1c_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
                wr_stb |=> (q & $past(wr_bits & ~side_in)) == '0);
            assert_w1c_no_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !(|side_in) |=> (q & ~$past(q)) == '0);
        end else if (IS_W1S) begin : g_w1s_chk
            assert_w1s_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
                wr_stb |=> (q & $past(wr_bits)) == $past(wr_bits));
            assert_w1s_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                ((|side_in) && !wr_stb) |=> (q & $past(side_in)) == '0);
            assert_w1s_no_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !(|side_in) |=> ($past(q) & ~q) == '0);
        end
    endgenerate

endmodule

// File: rtl/csr_field_wire.sv
module csr_field_wire #(
    parameter csr_field_pkg::field_kind_e KIND = csr_field_pkg::FK_RO,
    parameter int W = 4
) (
    input  logic         bus_rd_stb,
    input  logic         bus_wr_stb,
    input  logic [W-1:0] wr_bits,
    input  logic [W-1:0] per_in,
    output logic [W-1:0] rd_bits,
    output logic [W-1:0] per_out,
    output logic         per_stb
);
    localparam bit IS_RO = (KIND == csr_field_pkg::FK_RO);
    localparam bit IS_WO = (KIND == csr_field_pkg::FK_WO);

    assign rd_bits = per_in  & {W{IS_RO}};
    assign per_out = wr_bits & {W{IS_WO}};
    assign per_stb = (bus_rd_stb & IS_RO) | (bus_wr_stb & IS_WO);

endmodule

// File: rtl/typed_csr_reg.sv
module typed_csr_reg #(
    parameter int RW_W  = 4,
    parameter int CLR_W = 4,
    parameter int SET_W = 4,
    parameter int RO_W  = 4,
    parameter int WO_W  = 4,
    parameter int RSV_W = 4,
    parameter logic [RW_W-1:0]  CTL_RST  = 'hA,
    parameter logic [CLR_W-1:0] PEND_RST = '0,
    parameter logic [SET_W-1:0] ARM_RST  = '0,
    localparam int REG_W = RW_W + CLR_W + SET_W + RO_W + WO_W + RSV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rd_stb,
    input  logic             bus_wr_stb,
    input  logic [REG_W-1:0] bus_wr_data,
    output logic [REG_W-1:0] bus_rd_data,
    output logic [RW_W-1:0]  ctl_q,
    output logic [CLR_W-1:0] pend_q,
    input  logic [CLR_W-1:0] pend_set,
    output logic [SET_W-1:0] arm_q,
    input  logic [SET_W-1:0] arm_clr,
    input  logic [RO_W-1:0]  stat_in,
    output logic             stat_rd_stb,
    output logic [WO_W-1:0]  cmd_data,
    output logic             cmd_stb
);
    localparam int OFS_CLR = RW_W;
    localparam int OFS_SET = OFS_CLR + CLR_W;
    localparam int OFS_RO  = OFS_SET + SET_W;
    localparam int OFS_WO  = OFS_RO + RO_W;
    localparam int OFS_RSV = OFS_WO + WO_W;

    logic [RO_W-1:0]  stat_rd_bits;
    logic [RO_W-1:0]  stat_spare;
    logic [WO_W-1:0]  cmd_rd_bits;
    logic [RSV_W-1:0] rsv_rd_bits;
    logic [RSV_W-1:0] rsv_out;
    logic             rsv_stb;

    csr_field_store #(.KIND(csr_field_pkg::FK_RW), .W(RW_W), .RST(CTL_RST)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_stb(bus_wr_stb),
        .wr_bits(bus_wr_data[RW_W-1:0]), .side_in('0), .q(ctl_q)
    );

    csr_field_store #(.KIND(csr_field_pkg::FK_W1C), .W(CLR_W), .RST(PEND_RST)) u_pend (
        .clk(clk), .rst_n(rst_n), .wr_stb(bus_wr_stb),
        .wr_bits(bus_wr_data[OFS_CLR +: CLR_W]), .side_in(pend_set), .q(pend_q)
    );

    csr_field_store #(.KIND(csr_field_pkg::FK_W1S), .W(SET_W), .RST(ARM_RST)) u_arm (
        .clk(clk), .rst_n(rst_n), .wr_stb(bus_wr_stb),
        .wr_bits(bus_wr_data[OFS_SET +: SET_W]), .side_in(arm_clr), .q(arm_q)
    );

    csr_field_wire #(.KIND(csr_field_pkg::FK_RO), .W(RO_W)) u_stat (
        .bus_rd_stb(bus_rd_stb), .bus_wr_stb(bus_wr_stb),
        .wr_bits(bus_wr_data[OFS_RO +: RO_W]), .per_in(stat_in),
        .rd_bits(stat_rd_bits), .per_out(stat_spare), .per_stb(stat_rd_stb)
    );

    csr_field_wire #(.KIND(csr_field_pkg::FK_WO), .W(WO_W)) u_cmd (
        .bus_rd_stb(bus_rd_stb), .bus_wr_stb(bus_wr_stb),
        .wr_bits(bus_wr_data[OFS_WO +: WO_W]), .per_in('0),
        .rd_bits(cmd_rd_bits), .per_out(cmd_data), .per_stb(cmd_stb)
    );

    csr_field_wire #(.KIND(csr_field_pkg::FK_RSV), .W(RSV_W)) u_rsv (
        .bus_rd_stb(bus_rd_stb), .bus_wr_stb(bus_wr_stb),
        .wr_bits(bus_wr_data[OFS_RSV +: RSV_W]), .per_in('0),
        .rd_bits(rsv_rd_bits), .per_out(rsv_out), .per_stb(rsv_stb)
    );

    assign bus_rd_data = {rsv_rd_bits, cmd_rd_bits, stat_rd_bits, arm_q, pend_q, ctl_q};

    // Reserved and status fields must leave nothing on the peripheral side.
    assert_reserved_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_out == '0) && !rsv_stb && (stat_spare == '0));
    assert_wo_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_data[OFS_WO +: WO_W] == '0);
    assert_ro_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_stb == bus_rd_stb);

endmodule

// File: tb/typed_csr_reg_test.sv
module typed_csr_reg_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd_stb = 1'b0;
    logic        bus_wr_stb = 1'b0;
    logic [23:0] bus_wr_data = '0;
    logic [23:0] bus_rd_data;
    logic [3:0]  ctl_q, pend_q, arm_q, cmd_data;
    logic [3:0]  pend_set = '0;
    logic [3:0]  arm_clr = '0;
    logic [3:0]  stat_in = '0;
    logic        stat_rd_stb, cmd_stb;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 0;
    logic [3:0] exp_ctl, exp_pend, exp_arm;

    typed_csr_reg uut (
        .clk(clk), .rst_n(rst_n), .bus_rd_stb(bus_rd_stb), .bus_wr_stb(bus_wr_stb),
        .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data), .ctl_q(ctl_q),
        .pend_q(pend_q), .pend_set(pend_set), .arm_q(arm_q), .arm_clr(arm_clr),
        .stat_in(stat_in), .stat_rd_stb(stat_rd_stb), .cmd_data(cmd_data), .cmd_stb(cmd_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] m_rw(logic [3:0] q, logic wr, logic [3:0] wd);
        return wr ? wd : q;
    endfunction

    function automatic logic [3:0] m_w1c(logic [3:0] q, logic wr, logic [3:0] wd, logic [3:0] s);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) begin
            if (s[i])             r[i] = 1'b1;
            else if (wr && wd[i]) r[i] = 1'b0;
            else                  r[i] = q[i];
        end
        return r;
    endfunction

    function automatic logic [3:0] m_w1s(logic [3:0] q, logic wr, logic [3:0] wd, logic [3:0] c);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) begin
            if (wr && wd[i]) r[i] = 1'b1;
            else if (c[i])   r[i] = 1'b0;
            else             r[i] = q[i];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic rd, input logic wr, input logic [23:0] wd,
                        input logic [3:0] s, input logic [3:0] c, input logic [3:0] st);
        bus_rd_stb = rd; bus_wr_stb = wr; bus_wr_data = wd;
        pend_set = s; arm_clr = c; stat_in = st;
        #1;
        check("R1 stored fields in read data", {20'd0, bus_rd_data[11:0]}, {20'd0, exp_arm, exp_pend, exp_ctl});
        check("R6 status read data", {28'd0, bus_rd_data[15:12]}, {28'd0, st});
        check("R6 status read strobe", {31'd0, stat_rd_stb}, {31'd0, rd});
        check("R7 command data", {28'd0, cmd_data}, {28'd0, wd[19:16]});
        check("R7 command strobe", {31'd0, cmd_stb}, {31'd0, wr});
        check("R7 command reads zero", {28'd0, bus_rd_data[19:16]}, 32'd0);
        check("R8 reserved reads zero", {28'd0, bus_rd_data[23:20]}, 32'd0);
        @(posedge clk);
        exp_ctl  = m_rw(exp_ctl, wr, wd[3:0]);
        exp_pend = m_w1c(exp_pend, wr, wd[7:4], s);
        exp_arm  = m_w1s(exp_arm, wr, wd[11:8], c);
        @(negedge clk);
        check("R2 control value", {28'd0, ctl_q}, {28'd0, exp_ctl});
        check("R3 pending flags", {28'd0, pend_q}, {28'd0, exp_pend});
        check("R4 arm flags", {28'd0, arm_q}, {28'd0, exp_arm});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_sink;
        seed_sink = $urandom(32'h1c5a_7e03);
        exp_ctl = 4'hA; exp_pend = 4'h0; exp_arm = 4'h0;
        repeat (3) @(negedge clk);
        // reset state, R2 R3 R4
        check("R2 reset value", {28'd0, ctl_q}, 32'hA);
        check("R3 reset value", {28'd0, pend_q}, 32'h0);
        check("R4 reset value", {28'd0, arm_q}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: idle keeps reset value, then write
        step(1'b1, 1'b0, 24'h000005, 4'h0, 4'h0, 4'h3);
        step(1'b0, 1'b1, 24'h000005, 4'h0, 4'h0, 4'h0);
        // R3/R4: fill flags from their own sources
        step(1'b0, 1'b0, 24'h0, 4'hF, 4'h0, 4'h0);
        step(1'b0, 1'b1, 24'h000F05, 4'h0, 4'h0, 4'h0);
        // R5: writing zeros to flag bits leaves them set
        step(1'b1, 1'b1, 24'h000005, 4'h0, 4'h0, 4'h9);
        check("R5 pending kept on zero write", {28'd0, pend_q}, 32'hF);
        check("R5 arm kept on zero write", {28'd0, arm_q}, 32'hF);
        // R3 conflict: clear bits 0,1 from bus, set bit 0 from peripheral
        step(1'b0, 1'b1, 24'h000035, 4'h1, 4'h0, 4'h0);
        check("R3 set wins over clear", {28'd0, pend_q}, 32'hD);
        // R4 conflict: clear all from peripheral, bus sets bit 2
        step(1'b0, 1'b1, 24'h000405, 4'h0, 4'hF, 4'h0);
        check("R4 bus set wins over clear", {28'd0, arm_q}, 32'h4);
        // R8: reserved write of ones alters nothing else
        step(1'b1, 1'b1, 24'hF00005, 4'h0, 4'h0, 4'h6);
        check("R8 reserved write leaves pending", {28'd0, pend_q}, 32'hD);
        check("R8 reserved write leaves arm", {28'd0, arm_q}, 32'h4);
        // R7: command slice with strobe
        step(1'b0, 1'b1, 24'h0A0005, 4'h0, 4'h0, 4'h0);

        for (int k = 0; k < 400; k++) begin
            logic [23:0] wd;
            logic [3:0]  s, c;
            wd = 24'($urandom);
            s  = 4'($urandom & $urandom & $urandom);
            c  = 4'($urandom & $urandom & $urandom);
            step(1'($urandom), 1'($urandom), wd, s, c, 4'($urandom));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule